// File: doc/BRIEF.md
# Split MPS/LPS Binary Arithmetic Encoder

This block is the arithmetic coding core of a context-adaptive binary entropy encoder. Upstream logic delivers bins that are already binarized and classified. A regular bin arrives with a flag that says whether it is the less probable symbol (LPS) or the more probable symbol (MPS), together with the four candidate LPS sub-range widths of its context. A bypass bin arrives with its plain value. The bins go into a small internal queue. The core keeps a 9-bit range and a 10-bit low register, renormalizes both after every bin, and emits bitstream bits. A bit whose value still depends on a carry that may come later is held back as a deferred bit and released once that carry is known.

Regular bins are handled by two chained coders: an MPS coder and an LPS coder. Two queued bins are encoded in the same cycle only when the head bin is an MPS and the bin behind it is a regular LPS. Every other combination encodes a single bin, so the two coder paths stay close in logic depth. Bypass bins take their own path, which leaves the range alone. A flush request terminates the codeword after the queue has drained, then returns the core to its initial state.

Top module: `split_arith_encoder`

## Requirements
- R1: After reset the range is 510, low is 0 and there are no deferred bits. encCount is 0, every outValid bit is 0 and pushReady is 1.
- R2: Bins are taken only in a cycle where pushReady is 1. pushReady is 1 when at least two queue entries are free and no flush is pending. pushNum 1 takes lane 0, and pushNum 2 or 3 takes lane 0 followed by lane 1. When pushReady is 0, pushed bins have no effect and are never encoded.
- R3: When the head bin is a regular MPS (pushBypass 0, pushSym 0) and the next bin is a regular LPS (pushBypass 0, pushSym 1), both bins are encoded in one cycle and encCount reads 2.
- R4: A head MPS that is followed by anything other than a regular LPS, or by no bin, is encoded alone and encCount reads 1.
- R5: A head regular LPS is always encoded alone and encCount reads 1.
- R6: A bypass bin (pushBypass 1, value on pushSym) is encoded alone. The range does not change. low becomes 2*low, plus range when the value is 1. Then exactly one output step follows, using the limits 1024 and 512.
- R7: A regular bin takes its LPS width q from byte k of its 32-bit row, where k is range bits [7:6]. An MPS sets range to range-q. An LPS adds range-q to low and sets range to q. Renormalization then doubles range and low until range is at least 256, so range always stays between 256 and 510.
- R8: Each renormalization step emits one event. When low is below 256, the event is a 0. When low is at least 512, the event is a 1 and 512 is removed. Otherwise one deferred bit is added and 256 is removed. A 0 or 1 event fills output slot i with outValid[i]=1 and outBit[i]=value. Its outFollow field carries the number of deferred bits, and each of those stands for one copy of the inverted value that comes after the bit. Slots are read in increasing index order.
- R9: A flush pulse makes pushReady 0 from the next cycle on. Once the queue is empty, the core subtracts 2 from range, adds the new range to low, sets range to 2 and renormalizes. It then emits low bit 9, low bit 8 and a final 1, and returns to the reset state.
- R10: Bins pushed at one clock edge are issued no earlier than the cycle that follows. The encCount and output slots of an issue appear at the clock edge that ends the issue cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pushNum | input | 2 | Number of lanes offered this cycle (0..2, 3 acts as 2) |
| pushBypass | input | 2 | Per lane: 1 marks a bypass bin |
| pushSym | input | 2 | Per lane: LPS flag for regular bins, bin value for bypass bins |
| pushRow | input | 64 | Per lane, 32 bits: four 8-bit LPS widths indexed by range[7:6] |
| pushReady | output | 1 | Queue has room for two bins and no flush is pending |
| flush | input | 1 | Request codeword termination |
| outValid | output | 10 | Per slot: a bit is emitted |
| outBit | output | 10 | Per slot: emitted bit value |
| outFollow | output | 160 | Per slot, 16 bits: count of inverted bits following the slot bit |
| encCount | output | 2 | Bins encoded in the previous cycle |

## Verification
The bench runs a serial reference encoder that handles one bin per step. Against it, the bench goes after four things. The first is the pairing rule: a design that pairs two MPS bins or an LPS followed by an MPS would show encCount 2 where 1 is due. The second is the LPS width lookup after an MPS in the same cycle: reading the row with the range from before the MPS renormalization corrupts the stream after a few bins. The third is deferred-bit release across slots and cycles: losing or misplacing the deferred count shows up as missing or inverted runs of bits. The last is flushing: a design that accepts pushes while a flush is pending, or that does not restore the initial state, breaks every codeword that follows.

// File: rtl/sae_pkg.sv
package sae_pkg;
  localparam int RANGE_W       = 9;
  localparam int LOW_W         = 10;
  localparam int RLPS_W        = 8;
  localparam int ROW_W         = 4 * RLPS_W;
  localparam int LPS_MAX_SHIFT = 6;               // rLps >= 6 needs at most 6 doublings
  localparam int FLUSH_SHIFT   = 7;               // range 2 needs 7 doublings
  localparam int EV_SLOTS      = FLUSH_SHIFT + 3; // largest event count of any operation

  localparam logic [RANGE_W-1:0] RANGE_INIT = 9'd510;
  localparam logic [LOW_W:0]     LOW_QTR    = {2'b00, 1'b1, {(LOW_W-2){1'b0}}};
  localparam logic [LOW_W:0]     LOW_HALF   = {2'b01, {(LOW_W-1){1'b0}}};
  localparam logic [LOW_W+1:0]   BYP_FULL   = {2'b01, {LOW_W{1'b0}}};
  localparam logic [LOW_W+1:0]   BYP_HALF   = {3'b001, {(LOW_W-1){1'b0}}};

  typedef struct packed {
    logic             bypass;
    logic             sym;
    logic [ROW_W-1:0] row;
  } bin_t;

  typedef enum logic [2:0] {OP_NONE, OP_MPS, OP_LPS, OP_PAIR, OP_BYP, OP_FLUSH} op_e;

  typedef struct packed {
    op_e        op;
    logic [1:0] pop;
  } strobe_t;

  typedef enum logic [1:0] {EV_NONE, EV_ZERO, EV_ONE, EV_DEFER} ev_e;

  function automatic logic [RLPS_W-1:0] pickRlps(input logic [ROW_W-1:0] row,
                                                 input logic [RANGE_W-1:0] r);
    return row[RLPS_W*r[RANGE_W-2 -: 2] +: RLPS_W];
  endfunction

  function automatic ev_e stepCode(input logic [LOW_W:0] l);
    if (l < LOW_QTR) return EV_ZERO;
    else if (l >= LOW_HALF) return EV_ONE;
    else return EV_DEFER;
  endfunction

  function automatic logic [LOW_W:0] stepLow(input logic [LOW_W:0] l);
    logic [LOW_W:0] t;
    t = l;
    if (l >= LOW_HALF) t = l - LOW_HALF;
    else if (l >= LOW_QTR) t = l - LOW_QTR;
    return {t[LOW_W-1:0], 1'b0};
  endfunction
endpackage

// File: rtl/sae_bin_queue.sv
module sae_bin_queue
  import sae_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int FW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [1:0]    pushCnt,
  input  bin_t          lane0,
  input  bin_t          lane1,
  input  logic [1:0]    popCnt,
  output bin_t          head0,
  output bin_t          head1,
  output logic [FW-1:0] fill
);
  bin_t          mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;

  always_ff @(posedge clk) begin
    if (pushCnt != 2'd0) mem[wrPtr] <= lane0;
    if (pushCnt == 2'd2) mem[AW'(wrPtr + AW'(1))] <= lane1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      fill  <= '0;
    end else begin
      wrPtr <= wrPtr + AW'(pushCnt);
      rdPtr <= rdPtr + AW'(popCnt);
      fill  <= fill + FW'(pushCnt) - FW'(popCnt);
    end
  end

  assign head0 = mem[rdPtr];
  assign head1 = mem[AW'(rdPtr + AW'(1))];
endmodule

// File: rtl/sae_ctrl.sv
module sae_ctrl
  import sae_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int FW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          flush,
  input  logic [FW-1:0] fill,
  input  logic          headBypass,
  input  logic          headSym,
  input  logic          nextBypass,
  input  logic          nextSym,
  output strobe_t       stb,
  output logic          pushReady
);
  logic flushPend;

  // Issue rule: pair only an MPS at the head with a regular LPS behind it.
  always_comb begin
    stb.op  = OP_NONE;
    stb.pop = 2'd0;
    if (fill != '0) begin
      stb.pop = 2'd1;
      if (headBypass)                                  stb.op = OP_BYP;
      else if (headSym)                                stb.op = OP_LPS;
      else if (fill >= FW'(2) && !nextBypass && nextSym) begin
        stb.op  = OP_PAIR;
        stb.pop = 2'd2;
      end else                                         stb.op = OP_MPS;
    end else if (flushPend) begin
      stb.op = OP_FLUSH;
    end
  end

  assign pushReady = !flushPend && (int'(fill) + 2 <= DEPTH);

  always_ff @(posedge clk) begin
    if (!rstN) flushPend <= 1'b0;
    else       flushPend <= (flushPend && stb.op != OP_FLUSH) || flush;
  end
endmodule

// File: rtl/sae_datapath.sv
module sae_datapath
  import sae_pkg::*;
#(
  parameter int OUTST_W = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  strobe_t                     stb,
  input  logic [ROW_W-1:0]            rowA,
  input  logic                        symA,
  input  logic [ROW_W-1:0]            rowB,
  output logic [EV_SLOTS-1:0]         outValid,
  output logic [EV_SLOTS-1:0]         outBit,
  output logic [EV_SLOTS*OUTST_W-1:0] outFollow,
  output logic [1:0]                  encCount,
  output logic [RANGE_W-1:0]          curRange
);
  logic [RANGE_W-1:0] rangeQ, rangeD, r;
  logic [LOW_W-1:0]   lowQ, lowD;
  logic [LOW_W:0]     l;
  logic [LOW_W+1:0]   wide;
  logic [RLPS_W-1:0]  q;
  logic [OUTST_W-1:0] deferQ, deferD, cnt;
  ev_e                evs [EV_SLOTS];
  int                 base;

  logic [EV_SLOTS-1:0]         validD, bitD;
  logic [EV_SLOTS*OUTST_W-1:0] followD;

  // Range and low stages: M coder, then L coder chained on its result.
  always_comb begin
    r    = rangeQ;
    l    = {1'b0, lowQ};
    wide = '0;
    q    = '0;
    base = 0;
    for (int i = 0; i < EV_SLOTS; i++) evs[i] = EV_NONE;

    if (stb.op == OP_MPS || stb.op == OP_PAIR) begin
      q = pickRlps(rowA, r);
      r = r - RANGE_W'(q);
      if (!r[RANGE_W-1]) begin
        evs[0] = stepCode(l);
        l      = stepLow(l);
        r      = r << 1;
      end
      base = 1;
    end

    if (stb.op == OP_LPS || stb.op == OP_PAIR) begin
      q = pickRlps((stb.op == OP_PAIR) ? rowB : rowA, r);
      l = l + (LOW_W+1)'(r - RANGE_W'(q));
      r = RANGE_W'(q);
      for (int k = 0; k < LPS_MAX_SHIFT; k++) begin
        if (!r[RANGE_W-1]) begin
          evs[base+k] = stepCode(l);
          l           = stepLow(l);
          r           = r << 1;
        end
      end
    end

    if (stb.op == OP_BYP) begin
      wide = {l, 1'b0} + (symA ? {3'b000, r} : '0);
      if (wide >= BYP_FULL) begin
        evs[0] = EV_ONE;
        wide   = wide - BYP_FULL;
      end else if (wide < BYP_HALF) begin
        evs[0] = EV_ZERO;
      end else begin
        evs[0] = EV_DEFER;
        wide   = wide - BYP_HALF;
      end
      l = wide[LOW_W:0];
    end

    if (stb.op == OP_FLUSH) begin
      r = r - RANGE_W'(2);
      l = l + (LOW_W+1)'(r);
      r = RANGE_W'(2);
      for (int k = 0; k < FLUSH_SHIFT; k++) begin
        if (!r[RANGE_W-1]) begin
          evs[k] = stepCode(l);
          l      = stepLow(l);
          r      = r << 1;
        end
      end
      evs[FLUSH_SHIFT]   = l[LOW_W-1] ? EV_ONE : EV_ZERO;
      evs[FLUSH_SHIFT+1] = l[LOW_W-2] ? EV_ONE : EV_ZERO;
      evs[FLUSH_SHIFT+2] = EV_ONE;
      r = RANGE_INIT;
      l = '0;
    end

    rangeD = r;
    lowD   = l[LOW_W-1:0];
  end

  // Output stage: attach the deferred count to each resolved bit.
  always_comb begin
    cnt     = deferQ;
    validD  = '0;
    bitD    = '0;
    followD = '0;
    for (int i = 0; i < EV_SLOTS; i++) begin
      case (evs[i])
        EV_DEFER: cnt = cnt + OUTST_W'(1);
        EV_ZERO, EV_ONE: begin
          validD[i]                    = 1'b1;
          bitD[i]                      = (evs[i] == EV_ONE);
          followD[i*OUTST_W +: OUTST_W] = cnt;
          cnt                          = '0;
        end
        default: ;
      endcase
    end
    deferD = cnt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rangeQ    <= RANGE_INIT;
      lowQ      <= '0;
      deferQ    <= '0;
      outValid  <= '0;
      outBit    <= '0;
      outFollow <= '0;
      encCount  <= 2'd0;
    end else begin
      rangeQ    <= rangeD;
      lowQ      <= lowD;
      deferQ    <= deferD;
      outValid  <= validD;
      outBit    <= bitD;
      outFollow <= followD;
      encCount  <= stb.pop;
    end
  end

  assign curRange = rangeQ;
endmodule

// File: rtl/split_arith_encoder.sv
module split_arith_encoder
  import sae_pkg::*;
#(
  parameter int QDEPTH  = 4,
  parameter int OUTST_W = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [1:0]                  pushNum,
  input  logic [1:0]                  pushBypass,
  input  logic [1:0]                  pushSym,
  input  logic [2*ROW_W-1:0]          pushRow,
  output logic                        pushReady,
  input  logic                        flush,
  output logic [EV_SLOTS-1:0]         outValid,
  output logic [EV_SLOTS-1:0]         outBit,
  output logic [EV_SLOTS*OUTST_W-1:0] outFollow,
  output logic [1:0]                  encCount
);
  localparam int FW = $clog2(QDEPTH + 1);

  bin_t               lane0, lane1, head0, head1;
  logic [1:0]         pushCnt;
  logic [FW-1:0]      fill;
  strobe_t            stb;
  logic [RANGE_W-1:0] curRange;

  assign lane0   = '{bypass: pushBypass[0], sym: pushSym[0], row: pushRow[ROW_W-1:0]};
  assign lane1   = '{bypass: pushBypass[1], sym: pushSym[1], row: pushRow[2*ROW_W-1:ROW_W]};
  assign pushCnt = !pushReady ? 2'd0 : (pushNum == 2'd3 ? 2'd2 : pushNum);

  sae_bin_queue #(.DEPTH(QDEPTH)) u_queue (
    .clk(clk), .rstN(rstN), .pushCnt(pushCnt), .lane0(lane0), .lane1(lane1),
    .popCnt(stb.pop), .head0(head0), .head1(head1), .fill(fill)
  );

  sae_ctrl #(.DEPTH(QDEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .flush(flush), .fill(fill),
    .headBypass(head0.bypass), .headSym(head0.sym),
    .nextBypass(head1.bypass), .nextSym(head1.sym),
    .stb(stb), .pushReady(pushReady)
  );

  sae_datapath #(.OUTST_W(OUTST_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .rowA(head0.row), .symA(head0.sym),
    .rowB(head1.row), .outValid(outValid), .outBit(outBit), .outFollow(outFollow),
    .encCount(encCount), .curRange(curRange)
  );
endmodule

// File: rtl/sae_checker.sv
module sae_checker #(
  parameter int DEPTH   = 4,
  parameter int OUTST_W = 16,
  localparam int FW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic          flush,
  input logic          pushReady,
  input logic [1:0]    encCount,
  input logic [8:0]    curRange,
  input logic [FW-1:0] fill
);
  assert_range_window_R7: assert property (@(posedge clk) disable iff (!rstN)
    (curRange >= 9'd256) && (curRange <= 9'd510));

  assert_enc_max_R3: assert property (@(posedge clk) disable iff (!rstN)
    encCount <= 2'd2);

  assert_pair_source_R3: assert property (@(posedge clk) disable iff (!rstN)
    (encCount == 2'd2) |-> (int'($past(fill)) >= 2));

  assert_issue_source_R10: assert property (@(posedge clk) disable iff (!rstN)
    (encCount != 2'd0) |-> ($past(fill) != '0));

  assert_flush_block_R9: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> !pushReady);

  assert_fill_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    int'(fill) <= DEPTH);
endmodule

bind split_arith_encoder sae_checker #(.DEPTH(QDEPTH), .OUTST_W(OUTST_W)) u_chk (
  .clk(clk), .rstN(rstN), .flush(flush), .pushReady(pushReady),
  .encCount(encCount), .curRange(curRange), .fill(fill)
);

// File: tb/split_arith_encoder_tb.sv
`timescale 1ns/1ps
module split_arith_encoder_tb;
  import sae_pkg::*;
  localparam int QDEPTH  = 4;
  localparam int OUTST_W = 16;

  // {byp0, sym0, byp1, sym1, encCount in first issue cycle}
  localparam logic [5:0] VEC [7] = '{6'b00_00_01, 6'b00_01_10, 6'b01_00_01, 6'b01_01_01,
                                     6'b10_00_01, 6'b00_10_01, 6'b11_10_01};

  logic clk = 1'b0, rstN = 1'b0;
  always #10 clk = ~clk;

  logic [1:0]                  pushNum = '0, pushBypass = '0, pushSym = '0;
  logic [2*ROW_W-1:0]          pushRow = '0;
  logic                        pushReady, flush = 1'b0;
  logic [EV_SLOTS-1:0]         outValid, outBit;
  logic [EV_SLOTS*OUTST_W-1:0] outFollow;
  logic [1:0]                  encCount;

  split_arith_encoder #(.QDEPTH(QDEPTH), .OUTST_W(OUTST_W)) u_dut (
    .clk(clk), .rstN(rstN), .pushNum(pushNum), .pushBypass(pushBypass), .pushSym(pushSym),
    .pushRow(pushRow), .pushReady(pushReady), .flush(flush), .outValid(outValid),
    .outBit(outBit), .outFollow(outFollow), .encCount(encCount)
  );

  int checks = 0, fails = 0;
  bit expQ[$];
  int refRange = 510, refLow = 0, refDefer = 0;
  bit monOn = 1'b0;

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  // Serial reference encoder, one bin per step.
  task automatic refPut(bit b);
    expQ.push_back(b);
    repeat (refDefer) expQ.push_back(!b);
    refDefer = 0;
  endtask

  task automatic refRenorm();
    while (refRange < 256) begin
      if (refLow < 256) refPut(1'b0);
      else if (refLow >= 512) begin refLow -= 512; refPut(1'b1); end
      else begin refLow -= 256; refDefer++; end
      refRange = refRange * 2;
      refLow   = refLow * 2;
    end
  endtask

  task automatic refBin(bit byp, bit sym, logic [ROW_W-1:0] row);
    int q;
    if (byp) begin
      refLow = refLow * 2 + (sym ? refRange : 0);
      if (refLow >= 1024) begin refPut(1'b1); refLow -= 1024; end
      else if (refLow < 512) refPut(1'b0);
      else begin refLow -= 512; refDefer++; end
    end else begin
      q = int'(row[8*((refRange >> 6) & 3) +: 8]);
      if (!sym) refRange -= q;
      else begin refLow += refRange - q; refRange = q; end
      refRenorm();
    end
  endtask

  task automatic refFlush();
    refRange -= 2;
    refLow   += refRange;
    refRange  = 2;
    refRenorm();
    refPut(bit'((refLow >> 9) & 1));
    expQ.push_back(bit'((refLow >> 8) & 1));
    expQ.push_back(1'b1);
    refRange = 510; refLow = 0; refDefer = 0;
  endtask

  function automatic logic [ROW_W-1:0] randRow();
    logic [ROW_W-1:0] row;
    for (int k = 0; k < 4; k++) row[8*k +: 8] = 8'($urandom_range(128 + 32*k, 6));
    return row;
  endfunction

  // Drive at a negedge; the reference sees the bins only if they are taken.
  task automatic drive(int n, bit b0, bit s0, bit b1, bit s1);
    logic [ROW_W-1:0] r0, r1;
    r0 = randRow(); r1 = randRow();
    pushNum = 2'(n); pushBypass = {b1, b0}; pushSym = {s1, s0}; pushRow = {r1, r0};
    if (pushReady) begin
      if (n >= 1) refBin(b0, s0, r0);
      if (n >= 2) refBin(b1, s1, r1);
    end
  endtask

  task automatic cmpBit(bit b);
    bit e;
    if (expQ.size() == 0) check(1'b0, "R8", "unexpected stream bit", int'(b), -1);
    else begin
      e = expQ.pop_front();
      check(b == e, "R8", "stream bit", int'(b), int'(e));
    end
  endtask

  always @(negedge clk) begin
    if (monOn) begin
      for (int i = 0; i < EV_SLOTS; i++) begin
        if (outValid[i]) begin
          cmpBit(outBit[i]);
          for (int j = 0; j < int'(outFollow[i*OUTST_W +: OUTST_W]); j++) cmpBit(!outBit[i]);
        end
      end
    end
  end

  function automatic string tagOf(int i);
    case (i)
      0: return "R4";
      1: return "R3";
      2: return "R5";
      3: return "R5";
      4: return "R6";
      5: return "R4";
      default: return "R6";
    endcase
  endfunction

  task automatic doFlush();
    @(negedge clk);
    pushNum = '0;
    flush = 1'b1;
    refFlush();
    @(negedge clk);
    flush = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  // mode 0: bypass only, 1: regular only, 2: mixed
  task automatic runSegment(int cycles, int mode);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      if (pushReady) begin
        bit b0, b1, s0, s1;
        b0 = (mode == 0) || (mode == 2 && $urandom_range(9, 0) < 3);
        b1 = (mode == 0) || (mode == 2 && $urandom_range(9, 0) < 3);
        s0 = b0 ? bit'($urandom_range(1, 0)) : ($urandom_range(9, 0) < 3);
        s1 = b1 ? bit'($urandom_range(1, 0)) : ($urandom_range(9, 0) < 3);
        drive(int'($urandom_range(2, 0)), b0, s0, b1, s1);
      end else pushNum = '0;
    end
    doFlush();
  endtask

  initial begin
    #(20ns * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int f0;
    monOn = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(encCount == 2'd0, "R1", "encCount after reset", int'(encCount), 0);
    check(outValid == '0, "R1", "outValid after reset", int'(outValid), 0);
    check(pushReady == 1'b1, "R1", "pushReady after reset", int'(pushReady), 1);

    for (int i = 0; i < 7; i++) begin
      int first;
      first = int'(VEC[i][1:0]);
      @(negedge clk);
      drive(2, VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2]);
      @(negedge clk);
      pushNum = '0;
      check(encCount == 2'd0, "R10", "no issue in push cycle", int'(encCount), 0);
      @(negedge clk);
      check(int'(encCount) == first, tagOf(i), "first issue count", int'(encCount), first);
      @(negedge clk);
      check(int'(encCount) == 2 - first, tagOf(i), "second issue count", int'(encCount), 2 - first);
    end

    // Flush, then try to push while blocked.
    @(negedge clk);
    flush = 1'b1;
    refFlush();
    @(negedge clk);
    flush = 1'b0;
    check(pushReady == 1'b0, "R9", "pushReady during flush", int'(pushReady), 0);
    drive(2, 1'b0, 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    pushNum = '0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(encCount == 2'd0, "R2", "ignored push encodes nothing", int'(encCount), 0);
    end
    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R9", "flush codeword complete", expQ.size(), 0);
    check(pushReady == 1'b1, "R9", "pushReady back after flush", int'(pushReady), 1);

    f0 = fails;
    runSegment(600, 0);
    check(fails == f0 && expQ.size() == 0, "R6", "bypass-only stream", fails - f0, 0);
    f0 = fails;
    runSegment(1500, 1);
    check(fails == f0 && expQ.size() == 0, "R7", "regular-only stream", fails - f0, 0);
    f0 = fails;
    runSegment(3000, 2);
    check(fails == f0 && expQ.size() == 0, "R8", "mixed stream", fails - f0, 0);

    summary();
    $finish;
  end
endmodule